// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Sender

This block is the device-side engine that streams 16-bit words to a host over a parallel ATA-style Ultra DMA read burst. When the core asks for a burst, the block raises its request line. It then waits for the host to grant the bus and to release its stop line. After that it drives words onto the data bus and moves one word on every transition of its strobe, whether the strobe rises or falls. Words come from a valid/ready FIFO port. The word at the head of the FIFO is copied onto the bus first, and it is popped only at the strobe transition that carries it. A word that has been placed on the bus but not yet strobed therefore stays in the FIFO.

The host can pause the transfer by negating its ready line, and it ends the burst by raising its stop line. The block pauses on its own when the FIFO runs dry. During any pause the strobe holds its level. Once stop is seen, the block returns the strobe to its idle high level if needed, drops its request and waits for the grant to go away. It then reports completion with a one-cycle pulse. The word counter keeps the number of words moved in the last burst.

All timing limits are kept in nanoseconds and converted to clock-cycle counts by rounding up against the clock period parameter. A 3-bit transfer-mode input selects the set of limits in use.

Top module: `udma_in_sender`

## Requirements
- R1: While reset is asserted, and right after it is released, dev_req is 0, dev_strobe is 1, fifo_ready is 0, burst_done is 0 and word_count is 0.
- R2: A start pulse raises dev_req on the following cycle and clears word_count. No strobe transition occurs while host_ack_n is 1 or host_stop is 1.
- R3: The clock edge that first samples host_ack_n=0 and host_stop=0 during a request is called the grant edge. The first strobe transition happens ENV+SETUP+1 cycles after the grant edge, where ENV is the cycle count of a 20 ns envelope margin. This is well inside the first-strobe limit of every mode.
- R4: Every strobe transition that carries a word does three things together: it pulses fifo_ready for exactly that cycle, it presents the popped word on dev_data, and it adds one to word_count.
- R5: Between two successive strobe transitions of an uninterrupted stream there are exactly max(CYC, HOLD+SETUP) cycles, and never fewer than CYC. The minimum strobe cycle times are 112, 73, 54, 39, 25 and 16.8 ns for modes 0 to 5.
- R6: A word is placed on dev_data at least SETUP cycles before its strobe transition. It stays unchanged for at least HOLD cycles after that transition. The data setup times are 70, 48, 31, 20, 6.7 and 4.8 ns and the data hold times are 6.2 ns (4.8 ns in mode 5) for modes 0 to 5.
- R7: While host_rdy_n is 1, no word is strobed, starting from the first clock edge that samples it. Transfer resumes when host_rdy_n returns to 0.
- R8: When the FIFO is empty, the strobe holds its level and word_count stays unchanged. Transfer resumes once fifo_valid returns.
- R9: Once host_stop=1 is sampled, no further word is popped, and a word already on dev_data but not yet strobed stays in the FIFO. If the strobe is low, it makes one extra rise, at least CYC cycles after the previous transition, and that rise neither pops nor counts a word. dev_req then falls at least CYC cycles after the last transition.
- R10: After dev_req falls, burst_done pulses high for one cycle on the clock after host_ack_n is sampled at 1. word_count keeps the burst's total until the next start.
- R11: Mode values 6 and 7 use the mode 5 limits.
- R12: Every limit is converted to cycles as ceil(ps / CLK_PS), with a minimum of 1. At a 5 ns clock this gives CYC = 23, 15, 11, 8, 5, 4 and SETUP = 14, 10, 7, 4, 2, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Transfer mode selecting the timing set |
| start | input | 1 | One-cycle request to begin a burst |
| fifo_data | input | DW | Word at the head of the source FIFO, stable while valid |
| fifo_valid | input | 1 | Source FIFO holds a word |
| fifo_ready | output | 1 | Pop strobe, high in the cycle a word is strobed out |
| host_ack_n | input | 1 | Host grant, active low |
| host_stop | input | 1 | Host request to end the burst |
| host_rdy_n | input | 1 | Host ready to receive, active low |
| dev_req | output | 1 | Device burst request |
| dev_strobe | output | 1 | Source-synchronous data strobe, idle high |
| dev_data | output | DW | Data bus towards the host |
| burst_done | output | 1 | One-cycle pulse when the burst has fully closed |
| word_count | output | CNT_W | Words moved in the current or last burst |

## Verification
A wrong spacing or setup counter shows up at the first strobe transition after the fault, as a gap between transitions that is off by at least one cycle. A sequencer that has drifted out of step shows up within one word slot, in one of three ways: a pop with no matching transition, a word_count step with no pop, or a dev_data value that does not match the FIFO order. Errors in pause and stop handling show up within a single cycle as a transition during a host pause. At the end of the burst they show up as a low final strobe, a missing or doubled burst_done pulse, or a FIFO pop count that does not match word_count.

// File: rtl/udma_pkg.sv
package udma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ENV, ST_LOAD, ST_WAIT, ST_TERM, ST_REL
  } udma_state_t;

  localparam int unsigned ENV_PS = 20000;

  function automatic int unsigned mode_idx(input logic [2:0] m);
    return (m > 3'd5) ? 5 : int'(m);
  endfunction

  // minimum strobe-to-strobe time per mode, picoseconds
  function automatic int unsigned strobe_ps(input logic [2:0] m);
    case (mode_idx(m))
      0: return 112000;
      1: return 73000;
      2: return 54000;
      3: return 39000;
      4: return 25000;
      default: return 16800;
    endcase
  endfunction

  function automatic int unsigned setup_ps(input logic [2:0] m);
    case (mode_idx(m))
      0: return 70000;
      1: return 48000;
      2: return 31000;
      3: return 20000;
      4: return 6700;
      default: return 4800;
    endcase
  endfunction

  function automatic int unsigned hold_ps(input logic [2:0] m);
    return (mode_idx(m) == 5) ? 4800 : 6200;
  endfunction

  // round a minimum up to whole clocks, never below one
  function automatic int unsigned ps_to_cycles(input int unsigned ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/udma_mode_timer.sv
module udma_mode_timer
  import udma_pkg::*;
#(
  parameter int unsigned CLK_PS = 5000,
  parameter int unsigned TW     = 8
) (
  input  logic [2:0]    mode,
  output logic [TW-1:0] cyc_lim,
  output logic [TW-1:0] setup_lim,
  output logic [TW-1:0] hold_lim,
  output logic [TW-1:0] env_lim
);
  always_comb begin
    cyc_lim   = TW'(ps_to_cycles(strobe_ps(mode), CLK_PS));
    setup_lim = TW'(ps_to_cycles(setup_ps(mode), CLK_PS));
    hold_lim  = TW'(ps_to_cycles(hold_ps(mode), CLK_PS));
    env_lim   = TW'(ps_to_cycles(ENV_PS, CLK_PS));
  end
endmodule

// File: rtl/udma_downcount.sv
module udma_downcount #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/udma_in_sender.sv
module udma_in_sender
  import udma_pkg::*;
#(
  parameter int unsigned CLK_PS = 5000,
  parameter int unsigned DW     = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned TW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             start,
  input  logic [DW-1:0]    fifo_data,
  input  logic             fifo_valid,
  output logic             fifo_ready,
  input  logic             host_ack_n,
  input  logic             host_stop,
  input  logic             host_rdy_n,
  output logic             dev_req,
  output logic             dev_strobe,
  output logic [DW-1:0]    dev_data,
  output logic             burst_done,
  output logic [CNT_W-1:0] word_count
);
  udma_state_t st;

  logic [TW-1:0] cyc_lim, setup_lim, hold_lim, env_lim;
  logic gap_zero, hold_zero, ph_zero;

  // named internal events
  logic hs_ok, load_word, xfer_fire, term_fire, strobe_toggle, ph_load;
  logic [TW-1:0] ph_val;

  assign hs_ok         = !host_ack_n && !host_stop;
  assign load_word     = (st == ST_LOAD) && !host_stop && fifo_valid && hold_zero;
  assign xfer_fire     = (st == ST_WAIT) && !host_stop && !host_rdy_n && !host_ack_n
                         && gap_zero && ph_zero;
  assign term_fire     = (st == ST_TERM) && !dev_strobe && gap_zero;
  assign strobe_toggle = xfer_fire || term_fire;
  assign ph_load       = ((st == ST_REQ) && hs_ok) || load_word;
  assign ph_val        = load_word ? (setup_lim - TW'(1)) : (env_lim - TW'(1));
  assign fifo_ready    = xfer_fire;

  udma_mode_timer #(.CLK_PS(CLK_PS), .TW(TW)) u_timer (
    .mode(mode), .cyc_lim(cyc_lim), .setup_lim(setup_lim),
    .hold_lim(hold_lim), .env_lim(env_lim)
  );

  udma_downcount #(.W(TW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(strobe_toggle),
    .value(cyc_lim - TW'(1)), .zero(gap_zero)
  );

  udma_downcount #(.W(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(xfer_fire),
    .value(hold_lim - TW'(1)), .zero(hold_zero)
  );

  udma_downcount #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load),
    .value(ph_val), .zero(ph_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      dev_req    <= 1'b0;
      dev_strobe <= 1'b1;
      dev_data   <= '0;
      burst_done <= 1'b0;
      word_count <= '0;
    end else begin
      burst_done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st         <= ST_REQ;
          dev_req    <= 1'b1;
          word_count <= '0;
        end
        ST_REQ:  if (hs_ok) st <= ST_ENV;
        ST_ENV: begin
          if (host_stop)    st <= ST_TERM;
          else if (ph_zero) st <= ST_LOAD;
        end
        ST_LOAD: begin
          if (host_stop) st <= ST_TERM;
          else if (load_word) begin
            dev_data <= fifo_data;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (host_stop) st <= ST_TERM;
          else if (xfer_fire) begin
            dev_strobe <= ~dev_strobe;
            word_count <= word_count + CNT_W'(1);
            st         <= ST_LOAD;
          end
        end
        ST_TERM: begin
          if (term_fire) dev_strobe <= 1'b1;
          else if (dev_strobe && gap_zero) begin
            dev_req <= 1'b0;
            st      <= ST_REL;
          end
        end
        ST_REL: if (host_ack_n) begin
          st         <= ST_IDLE;
          burst_done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udma_in_sender_chk.sv
module udma_in_sender_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_req,
  input logic             dev_strobe,
  input logic             host_ack_n,
  input logic             host_stop,
  input logic             host_rdy_n,
  input logic             fifo_ready,
  input logic             burst_done,
  input logic [CNT_W-1:0] word_count,
  input logic             strobe_toggle,
  input logic [TW-1:0]    cyc_lim
);
  logic [TW-1:0] since;
  logic          seen;

  // cycles since the previous strobe transition, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (strobe_toggle) begin
      since <= TW'(1);
      seen  <= 1'b1;
    end else if (since != {TW{1'b1}}) begin
      since <= since + TW'(1);
    end
  end

  assert_pop_moves_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |=> (dev_strobe != $past(dev_strobe)));

  assert_pop_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |=> (word_count == $past(word_count) + CNT_W'(1)));

  assert_grant_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack_n || !dev_req) |-> !fifo_ready);

  assert_pause_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy_n |-> !fifo_ready);

  assert_stop_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_stop |-> !fifo_ready);

  assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_toggle && seen) |-> (since >= cyc_lim));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!dev_req && dev_strobe));
endmodule

bind udma_in_sender udma_in_sender_chk #(.CNT_W(CNT_W), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_strobe(dev_strobe),
  .host_ack_n(host_ack_n), .host_stop(host_stop), .host_rdy_n(host_rdy_n),
  .fifo_ready(fifo_ready), .burst_done(burst_done), .word_count(word_count),
  .strobe_toggle(strobe_toggle), .cyc_lim(cyc_lim)
);

// File: tb/udma_in_sender_test.sv
`timescale 1ns/1ps
module udma_in_sender_test;
  localparam int CLK_PS = 5000;
  localparam logic [15:0] MASK = 16'hA5C3;
  // mode, words, strobe ps, setup ps, hold ps
  localparam int VEC [7][5] = '{
    '{0, 4, 112000, 70000, 6200},
    '{1, 5,  73000, 48000, 6200},
    '{2, 6,  54000, 31000, 6200},
    '{3, 7,  39000, 20000, 6200},
    '{4, 8,  25000,  6700, 6200},
    '{5, 9,  16800,  4800, 4800},
    '{7, 5,  16800,  4800, 4800}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic start = 1'b0, host_ack_n = 1'b1, host_stop = 1'b1, host_rdy_n = 1'b1;
  logic fifo_ready, dev_req, dev_strobe, burst_done;
  logic [15:0] dev_data, word_count, fifo_data;
  logic fifo_valid;

  int pops = 0, lim = 0, cyc = 0;
  int tog_n = 0;
  int tog_stamp [256];
  logic [15:0] tog_dd [256];
  logic prev_s = 1'b1;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign fifo_valid = (pops < lim);
  assign fifo_data  = 16'(pops) ^ MASK;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && fifo_ready && fifo_valid) pops <= pops + 1;
  end

  always @(negedge clk) begin
    if (rst_n && dev_strobe !== prev_s) begin
      tog_stamp[tog_n % 256] = cyc;
      tog_dd[tog_n % 256]    = dev_data;
      tog_n = tog_n + 1;
    end
    prev_s = dev_strobe;
  end

  udma_in_sender #(.CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .start(start),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .host_ack_n(host_ack_n), .host_stop(host_stop), .host_rdy_n(host_rdy_n),
    .dev_req(dev_req), .dev_strobe(dev_strobe), .dev_data(dev_data),
    .burst_done(burst_done), .word_count(word_count)
  );

  function automatic int to_cyc(input int ps);
    int n = 0;
    while (n * CLK_PS < ps) n++;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_tog(input int target);
    int g = 0;
    while (tog_n < target && g < 3000) begin tick(1); g++; end
  endtask

  int p0, t0, c0;

  task automatic begin_burst(input int m, input int avail);
    mode = 3'(m);
    p0 = pops; t0 = tog_n; lim = pops + avail;
    start = 1'b1; tick(1); start = 1'b0;
    chk(dev_req == 1'b1, "R2", "request after start", dev_req, 1);
    chk(word_count == 0, "R2", "count cleared", word_count, 0);
    tick(6);
    chk(tog_n == t0, "R2", "no strobe before grant", tog_n - t0, 0);
    host_ack_n = 1'b0; host_stop = 1'b0; host_rdy_n = 1'b0;
    c0 = cyc;
  endtask

  task automatic end_burst(input int words);
    int g = 0;
    host_stop = 1'b1;
    while (dev_req && g < 3000) begin tick(1); g++; end
    chk(dev_strobe == 1'b1, "R9", "strobe idle high", dev_strobe, 1);
    chk(word_count == 16'(words), "R10", "word count", word_count, words);
    chk(burst_done == 1'b0, "R10", "no done before release", burst_done, 0);
    host_ack_n = 1'b1; tick(1);
    chk(burst_done == 1'b1, "R10", "done pulse", burst_done, 1);
    tick(1);
    chk(burst_done == 1'b0, "R10", "done single", burst_done, 0);
    chk(word_count == 16'(words), "R10", "count held", word_count, words);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int envc;
    envc = to_cyc(20000);
    tick(3);
    chk(dev_req == 0 && dev_strobe == 1 && fifo_ready == 0, "R1", "outputs in reset",
        {dev_req, dev_strobe, fifo_ready}, 3'b010);
    rst_n = 1'b1; tick(2);
    chk(dev_req == 0 && dev_strobe == 1 && burst_done == 0 && word_count == 0,
        "R1", "outputs after reset", {dev_req, dev_strobe, burst_done}, 3'b010);

    // vector table: one burst per mode
    for (int v = 0; v < 7; v++) begin
      int n, cy, su, ho, gap, bad, cnt_bad;
      n  = VEC[v][1];
      cy = to_cyc(VEC[v][2]); su = to_cyc(VEC[v][3]); ho = to_cyc(VEC[v][4]);
      gap = (cy > ho + su) ? cy : ho + su;
      begin_burst(VEC[v][0], n);
      wait_tog(t0 + n);
      chk(tog_stamp[t0 % 256] - c0 == envc + su + 2, "R3", "first strobe latency",
          tog_stamp[t0 % 256] - c0, envc + su + 2);
      bad = 0; cnt_bad = 0;
      for (int k = 1; k < n; k++)
        if (tog_stamp[(t0 + k) % 256] - tog_stamp[(t0 + k - 1) % 256] != gap) bad++;
      chk(bad == 0, "R5", "strobe spacing (R11 R12 mode rounding)", bad, 0);
      for (int k = 0; k < n; k++)
        if (tog_dd[(t0 + k) % 256] != (16'(p0 + k) ^ MASK)) cnt_bad++;
      chk(cnt_bad == 0, "R4", "words in order on strobe", cnt_bad, 0);
      end_burst(n);
      chk(tog_n - t0 == n + (n % 2), "R9", "total transitions", tog_n - t0, n + (n % 2));
      if (n % 2 == 1)
        chk(tog_stamp[(t0 + n) % 256] - tog_stamp[(t0 + n - 1) % 256] == cy,
            "R9", "final rise spacing", tog_stamp[(t0 + n) % 256] - tog_stamp[(t0 + n - 1) % 256], cy);
      chk(pops - p0 == n, "R4", "pops equal words", pops - p0, n);
    end

    // R6: setup and hold observed on the bus, mode 0
    begin
      int chg;
      begin_burst(0, 2);
      wait_tog(t0 + 1);
      chg = 0;
      for (int i = 0; i < to_cyc(6200); i++) begin
        if (dev_data != (16'(p0) ^ MASK)) chg++;
        tick(1);
      end
      chk(chg == 0, "R6", "data held after strobe", chg, 0);
      wait_tog(t0 + 2);
      chk(tog_dd[(t0 + 1) % 256] == (16'(p0 + 1) ^ MASK), "R6", "second word",
          tog_dd[(t0 + 1) % 256], 16'(p0 + 1) ^ MASK);
      end_burst(2);
    end

    // R7: host pause, mode 3
    begin
      int tp, bad;
      begin_burst(3, 10);
      wait_tog(t0 + 4);
      host_rdy_n = 1'b1; tp = tog_n;
      tick(40);
      chk(tog_n == tp, "R7", "no strobe in host pause", tog_n - tp, 0);
      chk(word_count == 16'(tp - t0), "R7", "count frozen", word_count, tp - t0);
      host_rdy_n = 1'b0;
      wait_tog(t0 + 10);
      bad = 0;
      for (int k = 0; k < 10; k++)
        if (tog_dd[(t0 + k) % 256] != (16'(p0 + k) ^ MASK)) bad++;
      chk(bad == 0, "R7", "data after resume", bad, 0);
      end_burst(10);
    end

    // R8: FIFO runs dry, mode 4
    begin
      int tp;
      begin_burst(4, 3);
      wait_tog(t0 + 3);
      tp = tog_n; tick(30);
      chk(tog_n == tp, "R8", "strobe steady when empty", tog_n - tp, 0);
      chk(word_count == 3, "R8", "count steady when empty", word_count, 3);
      lim = lim + 3;
      wait_tog(t0 + 6);
      chk(tog_dd[(t0 + 5) % 256] == (16'(p0 + 5) ^ MASK), "R8", "word after refill",
          tog_dd[(t0 + 5) % 256], 16'(p0 + 5) ^ MASK);
      end_burst(6);
    end

    // R9: stop with a word staged but not strobed, mode 0
    begin
      begin_burst(0, 10);
      wait_tog(t0 + 2);
      host_rdy_n = 1'b1;
      tick(40);
      chk(dev_data == (16'(p0 + 2) ^ MASK), "R9", "third word staged",
          dev_data, 16'(p0 + 2) ^ MASK);
      end_burst(2);
      chk(pops - p0 == 2, "R9", "staged word not popped", pops - p0, 2);
      chk(tog_n - t0 == 2, "R9", "no extra transition", tog_n - t0, 2);
      host_rdy_n = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule